// File: doc/BRIEF.md
# UART FIFO Ready and Interrupt Signaling

This block produces the two active-low ready strobes and the two interrupt requests of a single UART channel. It holds a receive FIFO and a transmit FIFO of 128 bytes each, and it keeps a live level counter for each one. Registered comparators check each level against a programmable threshold. A latch remembers a receive timeout pulse. Serial framing, baud generation and flow control sit outside the block. The receiver pushes bytes in and the host pops them. The host pushes transmit bytes and the shift register pops them.

Three modes decide what the ready strobes mean. In holding mode (FIFO off) each FIFO acts as a single byte register. In character mode the FIFO is on and the strobes follow empty or non-empty. In block mode the strobes serve bulk transfers: receive ready asserts at the threshold or on a timeout and holds until the FIFO drains, and transmit ready reports free space. A select input picks the empty condition for the transmit interrupt: either the FIFO is empty, or the FIFO and the shift register are both idle.

Top module: `uart_fifo_ready_ctrl`

## Requirements
- R1: `rx_level` and `tx_level` give occupancy from 0 to 128. Capacity is 128 when `fifo_en`=1 and 1 when `fifo_en`=0. A push into a full FIFO is dropped unless a pop is accepted in the same cycle. A pop from an empty FIFO is dropped. An accepted push together with an accepted pop leaves the level unchanged.
- R2: Bytes leave in arrival order. `rx_dout`/`tx_dout` show the oldest byte while the level is non-zero, and a pop removes it.
- R3: Holding mode (`fifo_en`=0): `rxrdy_n` is 0 when a byte is held, otherwise 1. `txrdy_n` is 0 when the transmit register is empty, otherwise 1.
- R4: Character mode (`fifo_en`=1, `block_mode`=0): `rxrdy_n` is 0 exactly when `rx_level`≥1. `txrdy_n` is 0 exactly when `tx_level`=0.
- R5: Block mode (`fifo_en`=1, `block_mode`=1): `rxrdy_n` goes to 0 in the cycle after the edge at which `rx_level` reaches the threshold or a timeout is latched. It stays 0 until `rx_level` becomes 0.
- R6: Block mode: `txrdy_n` is 1 only when `tx_level`=128, and 0 otherwise.
- R7: `rx_irq` with `fifo_en`=1 equals a flag registered at each edge as (new `rx_level` ≥ threshold). With `fifo_en`=0, `rx_irq` is 1 exactly when a byte is held.
- R8: With `tx_int_sel`=0, `tx_irq` is 0 while the registered flag (new `tx_level` ≥ threshold) is set, and 1 otherwise. With `fifo_en`=0 it is 1 exactly when `tx_level`=0.
- R9: With `tx_int_sel`=1 the rules of R8 apply, except that at `tx_level`=0 `tx_irq` is 1 only when `tx_shift_busy`=0.
- R10: A one-cycle `rx_timeout` pulse is latched and held until a cycle with `rx_pop`=1 and no new pulse. In block mode, a latched timeout with a non-empty receive FIFO pulls `rxrdy_n` low.
- R11: The 8-bit threshold inputs are used clamped into 1..128: 0 acts as 1, and values above 128 act as 128.
- R12: After synchronous reset both levels are 0, `rxrdy_n`=1, `txrdy_n`=0, `rx_irq`=0, and the timeout latch and block-mode hold are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFOs on, 0 = single holding register |
| block_mode | input | 1 | 1 = block-transfer strobes (only with fifo_en) |
| tx_int_sel | input | 1 | Transmit interrupt empty condition: 0 FIFO, 1 whole transmitter |
| rx_trig | input | 8 | Receive threshold (clamped 1..128) |
| tx_trig | input | 8 | Transmit threshold (clamped 1..128) |
| rx_push | input | 1 | Receiver writes a byte |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a byte |
| rx_dout | output | 8 | Oldest received byte |
| tx_push | input | 1 | Host writes a byte |
| tx_din | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Shift register takes a byte |
| tx_dout | output | 8 | Oldest transmit byte |
| tx_shift_busy | input | 1 | Shift register still sending |
| rx_timeout | input | 1 | Receive timeout pulse |
| rx_level | output | 8 | Receive FIFO occupancy |
| tx_level | output | 8 | Transmit FIFO occupancy |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A push and a pop can land on the same FIFO in one cycle, including when it is full or empty. A timeout pulse can land together with the read that would clear its latch. Directed steps force each pairing at the boundary levels 0, 1 and 128, and long random runs repeat them in every mode. A behavioural queue model in the bench decides which accesses take effect and which wins. Every cycle, the bench compares the levels, head bytes, strobes and interrupts against that model.

// File: rtl/uart_rdy_pkg.sv
// Package: shared mode encoding for the ready/interrupt block.
// Assumes: one mode is in effect per cycle, derived from two control inputs.
package uart_rdy_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_BLOCK  = 2'd2
    } rdy_mode_e;

    // Map the two control inputs onto one operating mode.
    function automatic rdy_mode_e mode_of(input logic fifo_on, input logic blk);
        if (!fifo_on) return MODE_HOLD;
        if (blk)      return MODE_BLOCK;
        return MODE_SINGLE;
    endfunction

endpackage

// File: rtl/uart_rdy_fifo.sv
// Module: byte FIFO with occupancy counter and a run-time capacity limit.
// Assumes: DEPTH is a power of two; cap is between 1 and DEPTH.
// Head byte is shown ahead on dout; lvl_next is the level after this edge.
module uart_rdy_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cap,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [LW-1:0] lvl,
    output logic [LW-1:0] lvl_next
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          pop_ok, push_ok;

    // Decide which accesses take effect this cycle.
    always_comb begin
        pop_ok  = pop && (lvl != '0);
        push_ok = push && ((lvl < cap) || pop_ok);
    end

    // Next occupancy from the accepted accesses.
    always_comb begin
        case ({push_ok, pop_ok})
            2'b10:   lvl_next = lvl + LW'(1);
            2'b01:   lvl_next = lvl - LW'(1);
            default: lvl_next = lvl;
        endcase
    end

    // Pointers and level counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            lvl  <= '0;
        end else begin
            if (push_ok) wptr <= wptr + AW'(1);
            if (pop_ok)  rptr <= rptr + AW'(1);
            lvl <= lvl_next;
        end
    end

    // Byte storage write port.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    assign dout = mem[rptr];

    // R1: occupancy never exceeds the storage size
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LW'(DEPTH));

    // R1: a lone pop on an empty FIFO leaves it empty
    a_r1_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == '0 && pop && !push) |=> (lvl == '0));

    // R1: push with pop on a non-empty FIFO keeps the level
    a_r1_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != '0 && pop && push) |=> $stable(lvl));

endmodule

// File: rtl/uart_rdy_trig.sv
// Module: registered threshold compare for one FIFO level.
// Assumes: raw threshold is clamped into 1..DEPTH; ge_q tracks the level
// registered on the same edge, so it never glitches.
module uart_rdy_trig #(
    parameter int DEPTH = 128,
    parameter int TW    = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] trig_raw,
    input  logic [LW-1:0] lvl_next,
    output logic          ge_d,
    output logic          ge_q
);

    int unsigned eff;

    // Clamp the threshold and compare against the coming level.
    always_comb begin
        if (trig_raw == '0)                     eff = 1;
        else if (int'(trig_raw) > DEPTH)        eff = DEPTH;
        else                                    eff = int'(trig_raw);
        ge_d = int'(lvl_next) >= eff;
    end

    // Register the compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) ge_q <= 1'b0;
        else        ge_q <= ge_d;
    end

endmodule

// File: rtl/uart_rdy_signal.sv
// Module: decodes mode, levels and threshold flags into the ready strobes
// and interrupt requests; owns the timeout latch and the block-mode hold.
// Assumes: levels and flags come from registers in the same clock domain.
module uart_rdy_signal
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rdy_mode_e     mode,
    input  logic          tx_int_sel,
    input  logic          tx_shift_busy,
    input  logic          rx_timeout,
    input  logic          rx_pop,
    input  logic [LW-1:0] rx_lvl,
    input  logic [LW-1:0] rx_lvl_next,
    input  logic [LW-1:0] tx_lvl,
    input  logic          rx_ge_d,
    input  logic          rx_ge_q,
    input  logic          tx_ge_q,
    output logic          rxrdy_n,
    output logic          txrdy_n,
    output logic          rx_irq,
    output logic          tx_irq
);

    logic tmo_q, tmo_d, hold_q, hold_d;

    // Next timeout latch: a new pulse wins over a clearing read.
    always_comb begin
        if (rx_timeout)  tmo_d = 1'b1;
        else if (rx_pop) tmo_d = 1'b0;
        else             tmo_d = tmo_q;
    end

    // Next block-mode hold: set by threshold or timeout, cleared on empty.
    always_comb begin
        if (rx_lvl_next == '0) hold_d = 1'b0;
        else                   hold_d = hold_q | rx_ge_d | tmo_d;
    end

    // Latch and hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            tmo_q  <= tmo_d;
            hold_q <= hold_d;
        end
    end

    // Output decode per operating mode.
    always_comb begin
        unique case (mode)
            MODE_BLOCK: begin
                rxrdy_n = !hold_q;
                txrdy_n = (tx_lvl == LW'(DEPTH));
            end
            default: begin
                rxrdy_n = (rx_lvl == '0);
                txrdy_n = (tx_lvl != '0);
            end
        endcase
        if (mode == MODE_HOLD) begin
            rx_irq = (rx_lvl != '0);
            tx_irq = (tx_lvl == '0) && !(tx_int_sel && tx_shift_busy);
        end else begin
            rx_irq = rx_ge_q;
            tx_irq = !tx_ge_q && ((tx_lvl != '0) || !(tx_int_sel && tx_shift_busy));
        end
    end

    // R5: once held, block-mode receive ready stays until the FIFO is empty
    a_r5_hold_until_empty: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> (hold_q || rx_lvl == '0));

    // R10: a timeout with stored data and no read sets the hold
    a_r10_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && !rx_pop && rx_lvl != '0) |=> hold_q);

endmodule

// File: rtl/uart_fifo_ready_ctrl.sv
// Module (top): one UART channel's FIFOs plus ready strobes and interrupts.
// Assumes: one clock; receiver pushes/host pops RX, host pushes/shifter pops TX.
module uart_fifo_ready_ctrl
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int TW    = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          block_mode,
    input  logic          tx_int_sel,
    input  logic [TW-1:0] rx_trig,
    input  logic [TW-1:0] tx_trig,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_din,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_dout,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_din,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_dout,
    input  logic          tx_shift_busy,
    input  logic          rx_timeout,
    output logic [LW-1:0] rx_level,
    output logic [LW-1:0] tx_level,
    output logic          rxrdy_n,
    output logic          txrdy_n,
    output logic          rx_irq,
    output logic          tx_irq
);

    rdy_mode_e     mode;
    logic [LW-1:0] cap, rx_lvl_next, tx_lvl_next;
    logic          rx_ge_d, rx_ge_q, tx_ge_d, tx_ge_q;

    // Mode and effective capacity.
    always_comb begin
        mode = mode_of(fifo_en, block_mode);
        cap  = fifo_en ? LW'(DEPTH) : LW'(1);
    end

    uart_rdy_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .cap(cap),
        .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
        .lvl(rx_level), .lvl_next(rx_lvl_next));

    uart_rdy_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .cap(cap),
        .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
        .lvl(tx_level), .lvl_next(tx_lvl_next));

    uart_rdy_trig #(.DEPTH(DEPTH), .TW(TW)) u_rx_trig (
        .clk(clk), .rst_n(rst_n), .trig_raw(rx_trig),
        .lvl_next(rx_lvl_next), .ge_d(rx_ge_d), .ge_q(rx_ge_q));

    uart_rdy_trig #(.DEPTH(DEPTH), .TW(TW)) u_tx_trig (
        .clk(clk), .rst_n(rst_n), .trig_raw(tx_trig),
        .lvl_next(tx_lvl_next), .ge_d(tx_ge_d), .ge_q(tx_ge_q));

    uart_rdy_signal #(.DEPTH(DEPTH)) u_signal (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .tx_int_sel(tx_int_sel), .tx_shift_busy(tx_shift_busy),
        .rx_timeout(rx_timeout), .rx_pop(rx_pop),
        .rx_lvl(rx_level), .rx_lvl_next(rx_lvl_next), .tx_lvl(tx_level),
        .rx_ge_d(rx_ge_d), .rx_ge_q(rx_ge_q), .tx_ge_q(tx_ge_q),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .rx_irq(rx_irq), .tx_irq(tx_irq));

    // R6: in block mode a non-full transmit FIFO never reports not-ready
    a_r6_block_tx_space: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLOCK && tx_level < LW'(DEPTH)) |-> !txrdy_n);

endmodule

// File: tb/uart_fifo_ready_ctrl_tb.sv
// Bench: behavioural queue model updated each rising edge, compared with the
// design on every falling edge, plus directed checks at the boundaries.
module uart_fifo_ready_ctrl_tb;

    localparam int DEPTH = 128;
    localparam time CYC  = 20ns;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       fifo_en = 0, block_mode = 0, tx_int_sel = 0;
    logic [7:0] rx_trig = 8'd1, tx_trig = 8'd1;
    logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic [7:0] rx_din = 0, tx_din = 0, rx_dout, tx_dout, rx_level, tx_level;
    logic       tx_shift_busy = 0, rx_timeout = 0;
    logic       rxrdy_n, txrdy_n, rx_irq, tx_irq;

    int checks = 0, errors = 0;
    bit started = 0, done = 0;

    always #(CYC/2) clk = ~clk;

    uart_fifo_ready_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .block_mode(block_mode),
        .tx_int_sel(tx_int_sel), .rx_trig(rx_trig), .tx_trig(tx_trig),
        .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
        .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
        .tx_shift_busy(tx_shift_busy), .rx_timeout(rx_timeout),
        .rx_level(rx_level), .tx_level(tx_level), .rxrdy_n(rxrdy_n),
        .txrdy_n(txrdy_n), .rx_irq(rx_irq), .tx_irq(tx_irq));

    // Reference model state.
    int rxq[$], txq[$];
    bit m_rx_ge, m_tx_ge, m_hold, m_tmo;

    function automatic int clampt(input int t);
        if (t == 0) return 1;
        if (t > DEPTH) return DEPTH;
        return t;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_rx_ge = 0; m_tx_ge = 0; m_hold = 0; m_tmo = 0;
        end else begin
            int cap;
            bit pk, uk;
            cap = fifo_en ? DEPTH : 1;
            pk = rx_pop && rxq.size() > 0;
            uk = rx_push && (rxq.size() < cap || pk);
            if (pk) void'(rxq.pop_front());
            if (uk) rxq.push_back(int'(rx_din));
            pk = tx_pop && txq.size() > 0;
            uk = tx_push && (txq.size() < cap || pk);
            if (pk) void'(txq.pop_front());
            if (uk) txq.push_back(int'(tx_din));
            m_tmo = rx_timeout ? 1'b1 : (rx_pop ? 1'b0 : m_tmo);
            m_rx_ge = rxq.size() >= clampt(int'(rx_trig));
            m_tx_ge = txq.size() >= clampt(int'(tx_trig));
            m_hold = (rxq.size() == 0) ? 1'b0 : (m_hold | m_rx_ge | m_tmo);
        end
        started = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            int rl, tl;
            bit e_rr, e_tr, e_ri, e_ti;
            rl = rxq.size(); tl = txq.size();
            if (fifo_en && block_mode) begin
                e_rr = !m_hold; e_tr = (tl == DEPTH);
            end else begin
                e_rr = (rl == 0); e_tr = (tl != 0);
            end
            if (!fifo_en) begin
                e_ri = rl != 0;
                e_ti = (tl == 0) && !(tx_int_sel && tx_shift_busy);
            end else begin
                e_ri = m_rx_ge;
                e_ti = !m_tx_ge && (tl != 0 || !(tx_int_sel && tx_shift_busy));
            end
            chk("R1 rx_level", int'(rx_level), rl);
            chk("R1 tx_level", int'(tx_level), tl);
            if (rl > 0) chk("R2 rx_dout", int'(rx_dout), rxq[0]);
            if (tl > 0) chk("R2 tx_dout", int'(tx_dout), txq[0]);
            chk(!fifo_en ? "R3 rxrdy_n" : block_mode ? "R5 rxrdy_n" : "R4 rxrdy_n",
                int'(rxrdy_n), int'(e_rr));
            chk(!fifo_en ? "R3 txrdy_n" : block_mode ? "R6 txrdy_n" : "R4 txrdy_n",
                int'(txrdy_n), int'(e_tr));
            chk("R7 rx_irq", int'(rx_irq), int'(e_ri));
            chk(tx_int_sel ? "R9 tx_irq" : "R8 tx_irq", int'(tx_irq), int'(e_ti));
        end
    end

    // One stimulus cycle: drive at edge+2, hold through the next edge.
    task automatic step(input bit rp, input bit ro, input bit tp, input bit to, input bit tm);
        rx_push = rp; rx_pop = ro; tx_push = tp; tx_pop = to; rx_timeout = tm;
        rx_din = rx_din + 8'd1; tx_din = tx_din + 8'd3;
        @(posedge clk); #2;
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; rx_timeout = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0, 1, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CYC * 100000);
        errors++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R12: reset state
        chk("R12 rx_level", int'(rx_level), 0);
        chk("R12 rxrdy_n", int'(rxrdy_n), 1);
        chk("R12 txrdy_n", int'(txrdy_n), 0);
        chk("R12 rx_irq", int'(rx_irq), 0);
        chk("R12 tx_irq", int'(tx_irq), 1);

        // Holding mode
        step(1, 0, 1, 0, 0);
        chk("R3 rxrdy_n held", int'(rxrdy_n), 0);
        chk("R3 txrdy_n held", int'(txrdy_n), 1);
        step(1, 0, 0, 0, 0);
        chk("R1 holding capacity", int'(rx_level), 1);
        step(1, 1, 0, 0, 0);
        chk("R1 hold push+pop", int'(rx_level), 1);
        tx_int_sel = 1; tx_shift_busy = 1;
        step(0, 1, 0, 1, 0);
        chk("R9 busy shifter", int'(tx_irq), 0);
        tx_shift_busy = 0; step(0, 0, 0, 0, 0);
        chk("R9 idle shifter", int'(tx_irq), 1);
        tx_int_sel = 0;

        // Character mode
        fifo_en = 1; rx_trig = 8'd3;
        repeat (3) step(1, 0, 1, 0, 0);
        chk("R7 at threshold", int'(rx_irq), 1);
        chk("R4 txrdy_n", int'(txrdy_n), 1);
        step(0, 1, 0, 0, 0);
        chk("R7 below threshold", int'(rx_irq), 0);
        chk("R4 rxrdy_n", int'(rxrdy_n), 0);
        step(1, 1, 0, 0, 0);
        chk("R1 push+pop", int'(rx_level), 2);
        drain();

        // Block mode receive hysteresis
        block_mode = 1; rx_trig = 8'd4;
        repeat (3) step(1, 0, 0, 0, 0);
        chk("R5 below trig", int'(rxrdy_n), 1);
        step(1, 0, 0, 0, 0);
        chk("R5 reach trig", int'(rxrdy_n), 0);
        repeat (3) step(0, 1, 0, 0, 0);
        chk("R5 held at 1", int'(rxrdy_n), 0);
        step(0, 1, 0, 0, 0);
        chk("R5 released", int'(rxrdy_n), 1);
        repeat (2) step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        chk("R10 timeout", int'(rxrdy_n), 0);
        step(0, 1, 0, 0, 1);
        chk("R10 pulse beats read", int'(rxrdy_n), 0);
        step(0, 1, 0, 0, 0);
        chk("R10 empty releases", int'(rxrdy_n), 1);

        // Block mode transmit full
        tx_trig = 8'd100;
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, 0, 0);
        chk("R1 tx full", int'(tx_level), DEPTH);
        chk("R6 full", int'(txrdy_n), 1);
        step(0, 0, 0, 1, 0);
        chk("R6 one free", int'(txrdy_n), 0);
        chk("R8 above trig", int'(tx_irq), 0);
        tx_int_sel = 1; tx_shift_busy = 1;
        drain();
        chk("R9 empty busy", int'(tx_irq), 0);
        tx_shift_busy = 0; step(0, 0, 0, 0, 0);
        chk("R9 empty idle", int'(tx_irq), 1);

        // Threshold clamping
        block_mode = 0; rx_trig = 8'd0;
        step(1, 0, 0, 0, 0);
        chk("R11 zero acts as one", int'(rx_irq), 1);
        drain();
        rx_trig = 8'd200;
        for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 0, 0);
        chk("R11 127 below", int'(rx_irq), 0);
        step(1, 0, 0, 0, 0);
        chk("R11 128 reached", int'(rx_irq), 1);
        drain();

        // Random mix of all inputs and modes
        for (int i = 0; i < 6000; i++) begin
            if (i % 200 == 0) begin
                fifo_en = ($urandom % 4) != 0;
                block_mode = $urandom % 2;
                tx_int_sel = $urandom % 2;
                rx_trig = 8'($urandom % 140);
                tx_trig = 8'($urandom % 140);
            end
            tx_shift_busy = $urandom % 2;
            step(($urandom % 8) < 5, ($urandom % 8) < 3, ($urandom % 8) < 5,
                 ($urandom % 8) < 3, ($urandom % 50) == 0);
        end
        finish_run();
    end

endmodule